// File: doc/BRIEF.md
# Dual-Endian Byte-Addressable Word Memory

This block is a single-port synchronous memory built from 32-bit words and addressed by byte. The two low bits of the byte address select one of four byte lanes inside a word; the remaining bits select the word. A run-time mode input chooses how the lane offset maps onto bit positions: in big-endian mode the lowest offset is the most significant byte, and in little-endian mode it is the least significant byte. Changing the mode never moves stored data. Only the mapping used by later byte accesses changes.

One request is taken per cycle. A request is either a byte access or a word access, and either a read or a write. Read data appears in a register one cycle after the request, together with a valid strobe. A word access must sit on a byte address that is a multiple of four. A word access that is not aligned touches nothing and raises an error strobe in the following cycle instead.

Top module: `dual_endian_mem`

## Requirements
- R1: The word index of any access is the byte address with its two low bits dropped, so byte addresses 4k to 4k+3 all fall in word k.
- R2: In little-endian mode (mode_big_i=0) a byte access at offset k (address bits 1:0) uses word bits 8k+7 down to 8k.
- R3: In big-endian mode (mode_big_i=1) a byte access at offset k uses word bits 8(3-k)+7 down to 8(3-k), so offset 0 is bits 31..24.
- R4: An aligned word write (size_i=1) stores all 32 bits of wr_data_i, and a word read returns those 32 bits unchanged in either mode.
- R5: A byte write (size_i=0) stores wr_data_i[7:0] in the selected lane only, and the other three lanes of that word keep their contents.
- R6: A byte read returns the selected byte in rd_data_o[7:0] with rd_data_o[31:8] equal to zero.
- R7: An accepted read request raises rd_valid_o in the next cycle only, with its data on rd_data_o in that cycle, and a read does not change the stored data.
- R8: A word access whose address bits 1:0 are not 00 raises addr_err_o in the next cycle, keeps rd_valid_o low and rd_data_o unchanged, and writes nothing.
- R9: Changing mode_big_i leaves stored data untouched, so a word written in one mode reads back identically in the other.
- R10: While rst_n is low, rd_valid_o, addr_err_o and rd_data_o are all zero.
- R11: A cycle with req_i low leaves rd_valid_o and addr_err_o low in the next cycle and rd_data_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 1 | Access request for this cycle |
| wr_en_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 1 | 1 = 32-bit word access, 0 = byte access |
| mode_big_i | input | 1 | 1 = big-endian lane mapping, 0 = little-endian |
| addr_i | input | ADDR_W | Byte address |
| wr_data_i | input | 32 | Write data; a byte write uses bits 7:0 |
| rd_data_o | output | 32 | Registered read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after an accepted read |
| addr_err_o | output | 1 | Misaligned word access, one cycle after the request |

## Verification
The embedded properties watch the cycle timing on every clock. They check that rd_valid_o follows an accepted read, that addr_err_o follows a misaligned word request, that the two strobes never coincide, that byte reads are zero-extended, that rd_data_o holds when nothing is returned, and that the lane write enables only ever take the forms none, one lane or all four. Only the bench's scenarios can show which data ends up where. It sweeps every byte address in both modes and compares against an arithmetic model to show the lane mapping, the preservation of neighbouring lanes, the survival of data across mode changes and the absence of writes from misaligned requests.

// File: rtl/dem_pkg.sv
package dem_pkg;
  localparam int unsigned WORD_BITS  = 32;
  localparam int unsigned LANE_BITS  = 8;
  localparam int unsigned LANES      = WORD_BITS / LANE_BITS;
  localparam int unsigned LANE_SEL_W = $clog2(LANES);

  typedef enum logic {
    ACC_BYTE = 1'b0,
    ACC_WORD = 1'b1
  } acc_size_e;
endpackage

// File: rtl/dem_lane_map.sv
module dem_lane_map
  import dem_pkg::*;
(
  input  logic                  req,
  input  logic                  wr_en,
  input  acc_size_e             size,
  input  logic                  mode_big,
  input  logic [LANE_SEL_W-1:0] offset,
  output logic [LANE_SEL_W-1:0] lane_sel,
  output logic [LANES-1:0]      lane_we,
  output logic                  misaligned,
  output logic                  rd_fire
);
  logic [LANES-1:0] one_lane;

  always_comb begin
    misaligned = req && (size == ACC_WORD) && (offset != '0);
    // big-endian: offset k lands in lane (LANES-1-k)
    lane_sel   = mode_big ? LANE_SEL_W'(LANES - 1 - int'(offset)) : offset;
    one_lane   = LANES'(1) << lane_sel;
    rd_fire    = req && !wr_en && !misaligned;
    lane_we    = '0;
    if (req && wr_en && !misaligned) begin
      lane_we = (size == ACC_WORD) ? {LANES{1'b1}} : one_lane;
    end
  end
endmodule

// File: rtl/dem_store.sv
module dem_store
  import dem_pkg::*;
#(
  parameter int unsigned WORDS = 64,
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LANES-1:0]     lane_we,
  input  logic [IDX_W-1:0]     idx,
  input  logic [WORD_BITS-1:0] wr_lanes,
  output logic [WORD_BITS-1:0] rd_word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_BITS-1:0] bank [WORDS];

    always_ff @(posedge clk) begin
      if (lane_we[g]) begin
        bank[idx] <= wr_lanes[g*LANE_BITS +: LANE_BITS];
      end
    end

    assign rd_word[g*LANE_BITS +: LANE_BITS] = bank[idx];
  end

  // R5: a write enables no lane, exactly one lane, or the whole word
  assert_lane_we_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(lane_we) == 0) || ($countones(lane_we) == 1) ||
    ($countones(lane_we) == LANES));
endmodule

// File: rtl/dem_read_fmt.sv
module dem_read_fmt
  import dem_pkg::*;
(
  input  logic [WORD_BITS-1:0]  rd_word,
  input  acc_size_e             size,
  input  logic [LANE_SEL_W-1:0] lane_sel,
  output logic [WORD_BITS-1:0]  fmt_data
);
  logic [LANE_BITS-1:0] picked;

  always_comb begin
    picked = rd_word[lane_sel*LANE_BITS +: LANE_BITS];
    if (size == ACC_WORD) begin
      fmt_data = rd_word;
    end else begin
      fmt_data = {{(WORD_BITS-LANE_BITS){1'b0}}, picked};
    end
  end
endmodule

// File: rtl/dual_endian_mem.sv
module dual_endian_mem
  import dem_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned IDX_W = ADDR_W - LANE_SEL_W,
  localparam int unsigned WORDS = 1 << IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_i,
  input  logic                 wr_en_i,
  input  logic                 size_i,
  input  logic                 mode_big_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [WORD_BITS-1:0] wr_data_i,
  output logic [WORD_BITS-1:0] rd_data_o,
  output logic                 rd_valid_o,
  output logic                 addr_err_o
);
  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  acc_size_e             acc_size;
  logic                  req_g;
  logic [LANE_SEL_W-1:0] lane_sel;
  logic [LANES-1:0]      lane_we;
  logic                  misaligned;
  logic                  rd_fire;
  logic [WORD_BITS-1:0]  wr_lanes;
  logic [WORD_BITS-1:0]  rd_word;
  logic [WORD_BITS-1:0]  fmt_data;

  assign acc_size = acc_size_e'(size_i);
  assign req_g    = req_i && rst_sync_n;
  // byte writes replicate the byte so every lane sees it
  assign wr_lanes = (acc_size == ACC_WORD) ? wr_data_i
                                           : {LANES{wr_data_i[LANE_BITS-1:0]}};

  dem_lane_map u_lane_map (
    .req        (req_g),
    .wr_en      (wr_en_i),
    .size       (acc_size),
    .mode_big   (mode_big_i),
    .offset     (addr_i[LANE_SEL_W-1:0]),
    .lane_sel   (lane_sel),
    .lane_we    (lane_we),
    .misaligned (misaligned),
    .rd_fire    (rd_fire)
  );

  dem_store #(.WORDS(WORDS)) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lane_we  (lane_we),
    .idx      (addr_i[ADDR_W-1:LANE_SEL_W]),
    .wr_lanes (wr_lanes),
    .rd_word  (rd_word)
  );

  dem_read_fmt u_read_fmt (
    .rd_word  (rd_word),
    .size     (acc_size),
    .lane_sel (lane_sel),
    .fmt_data (fmt_data)
  );

  // next state
  logic                 valid_d, err_d, data_en;
  logic [WORD_BITS-1:0] data_d;

  always_comb begin
    valid_d = rd_fire;
    err_d   = misaligned;
    data_en = rd_fire;
    data_d  = fmt_data;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_valid_o <= 1'b0;
      addr_err_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= valid_d;
      addr_err_o <= err_d;
      if (data_en) begin
        rd_data_o <= data_d;
      end
    end
  end

  // R7: an aligned read request is answered in the next cycle
  assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && !wr_en_i && !(size_i && (addr_i[1:0] != 2'b00))) |=> rd_valid_o);

  // R8: a misaligned word request flags an error in the next cycle
  assert_misalign_flag_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && size_i && (addr_i[1:0] != 2'b00)) |=> (addr_err_o && !rd_valid_o));

  // R8: the error strobe and the valid strobe never coincide
  assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    addr_err_o |-> !rd_valid_o);

  // R8: a misaligned word request enables no lane for writing
  assert_misalign_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && size_i && (addr_i[1:0] != 2'b00)) |-> (lane_we == '0));

  // R6: byte reads come back with the upper 24 bits clear
  assert_byte_zext_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_valid_o && !$past(size_i)) |-> (rd_data_o[31:8] == 24'h0));

  // R11: an idle cycle produces no strobe
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_i |=> (!rd_valid_o && !addr_err_o));

  // R11: read data holds when nothing is returned
  assert_data_hold_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_valid_o |-> $stable(rd_data_o));
endmodule

// File: tb/dual_endian_mem_tb.sv
`timescale 1ns/1ps
module dual_endian_mem_tb;
  localparam int ADDR_W = 8;
  localparam int WORDS  = 1 << (ADDR_W - 2);
  localparam int BYTES  = 1 << ADDR_W;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i, wr_en_i, size_i, mode_big_i;
  logic [ADDR_W-1:0] addr_i;
  logic [31:0] wr_data_i;
  logic [31:0] rd_data_o;
  logic        rd_valid_o, addr_err_o;

  always #2 clk = ~clk;

  dual_endian_mem #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en_i(wr_en_i),
    .size_i(size_i), .mode_big_i(mode_big_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .addr_err_o(addr_err_o)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;
  logic [31:0] model [WORDS];
  logic [31:0] got_data;
  logic        got_valid, got_err;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lane_of(input logic big, input int off);
    return big ? 3 - off : off;
  endfunction

  function automatic logic [31:0] pattern(input int i);
    return (32'h9E3779B9 * i) ^ 32'h1234ABCD;
  endfunction

  // one request; outputs captured just after the edge that registers them
  task automatic access(input logic we, input logic wsz, input logic big,
                        input int a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; wr_en_i = we; size_i = wsz; mode_big_i = big;
    addr_i = ADDR_W'(a); wr_data_i = d;
    @(posedge clk);
    #1;
    got_data = rd_data_o; got_valid = rd_valid_o; got_err = addr_err_o;
    req_i = 1'b0;
    if (we && !(wsz && (a % 4 != 0))) begin
      if (wsz) model[a/4] = d;
      else model[a/4][lane_of(big, a%4)*8 +: 8] = d[7:0];
    end
  endtask

  task automatic read_all_words(input string req, input logic big);
    for (int w = 0; w < WORDS; w++) begin
      access(1'b0, 1'b1, big, w*4, 32'h0);
      check({req, " word data"}, got_data, model[w]);
      check("R7 valid after read", {31'b0, got_valid}, 32'd1);
    end
  endtask

  initial begin
    req_i = 0; wr_en_i = 0; size_i = 0; mode_big_i = 0; addr_i = '0; wr_data_i = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset valid", {31'b0, rd_valid_o}, 32'd0);
    check("R10 reset err", {31'b0, addr_err_o}, 32'd0);
    check("R10 reset data", rd_data_o, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R4: fill every word in little-endian mode, read back in big-endian (R9)
    for (int w = 0; w < WORDS; w++) access(1'b1, 1'b1, 1'b0, w*4, pattern(w));
    read_all_words("R4 R9", 1'b1);
    read_all_words("R4", 1'b0);

    // R2 R3 R6 R1: byte reads at every address in both modes
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < BYTES; a++) begin
        access(1'b0, 1'b0, logic'(m), a, 32'h0);
        check(m ? "R3 big byte read" : "R2 little byte read", got_data,
              {24'h0, model[a/4][lane_of(logic'(m), a%4)*8 +: 8]});
        check("R7 byte valid", {31'b0, got_valid}, 32'd1);
      end
    end

    // R5: byte writes at every address, mode chosen by address bit 3
    for (int a = 0; a < BYTES; a++) begin
      access(1'b1, 1'b0, logic'((a >> 3) & 1), a, {24'hFFFFFF, 8'(a ^ 8'h5C)});
      check("R7 no valid on write", {31'b0, got_valid}, 32'd0);
    end
    read_all_words("R5 R1", 1'b0);

    // R8: misaligned word writes and reads leave memory untouched
    for (int w = 0; w < WORDS; w += 7) begin
      for (int off = 1; off < 4; off++) begin
        logic [31:0] held;
        held = got_data;
        access(1'b1, 1'b1, logic'(off & 1), w*4 + off, 32'hDEADBEEF);
        check("R8 err on misaligned write", {31'b0, got_err}, 32'd1);
        check("R8 no valid on misaligned", {31'b0, got_valid}, 32'd0);
        access(1'b0, 1'b1, logic'(off & 1), w*4 + off, 32'h0);
        check("R8 err on misaligned read", {31'b0, got_err}, 32'd1);
        check("R8 data held", got_data, held);
      end
    end
    read_all_words("R8 unchanged", 1'b1);

    // R11: idle cycle
    begin
      logic [31:0] held;
      held = rd_data_o;
      @(posedge clk); #1;
      check("R11 idle valid", {31'b0, rd_valid_o}, 32'd0);
      check("R11 idle err", {31'b0, addr_err_o}, 32'd0);
      check("R11 idle data", rd_data_o, held);
    end

    // R9: word write in big-endian mode, byte view in little-endian mode
    access(1'b1, 1'b1, 1'b1, 8, 32'hA1B2C3D4);
    access(1'b0, 1'b0, 1'b0, 8, 32'h0);
    check("R9 R2 low offset little", got_data, 32'h000000D4);
    access(1'b0, 1'b0, 1'b1, 8, 32'h0);
    check("R9 R3 low offset big", got_data, 32'h000000A1);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule